// File: doc/BRIEF.md
# Packet Framing RAM Write Controller

This block sits between a byte-wide packet stream and a single-port receive RAM. The stream delivers one byte per clock while a packet is in progress. A start strobe marks the first byte of a packet and an end strobe marks the last byte. The controller turns this framing into the RAM's write enable, write address and write data. Packets of any length are stored back to back in consecutive locations. The gap between packets may last any number of cycles.

The write pointer is not reset between packets, so each packet begins in the location right after the previous packet's last byte. When the final location has been written, the block raises a full flag and refuses every later byte. This stops stored data from ever being overwritten. Only a reset clears the full condition. The write enable, address and data are all registered, so the RAM sees them together on the clock edge that follows the byte's arrival.

Top module: `pkt_ram_wr_ctrl`

## Requirements
- R1: While `rst_ni` is low, `wr_en_o` is 0, `wr_addr_o` is 0 and `full_o` is 0. After reset is released, the first stored byte goes to address 0.
- R2: When `sop_i` is high while idle, that cycle's `data_i` is written. `wr_en_o` is high and `wr_data_o` equals that byte one clock later.
- R3: Every byte from the start byte up to and including the byte marked by `eop_i` is written, one byte per cycle, at consecutive addresses. `wr_en_o` is low in the cycle after the end byte's write unless a new start arrives.
- R4: Bytes presented while idle with `sop_i` low are discarded, and `wr_en_o` stays 0.
- R5: A new packet is stored starting at the address one above the last byte of the previous packet, however long the idle gap.
- R6: A packet with `sop_i` and `eop_i` high in the same cycle writes exactly one location and returns the block to idle.
- R7: A high `sop_i` inside a packet, before its end byte, is treated as an ordinary data byte. It does not restart the packet or change the address sequence.
- R8: `full_o` rises in the same cycle that the write to address 2^ADDR_W-1 (1023 by default) is presented, and not before.
- R9: Each of the 2^ADDR_W locations is written exactly once before `full_o` rises. If the memory fills mid-packet, the remaining bytes of that packet are discarded.
- R10: Once `full_o` is high, it stays high until reset, and `wr_en_o` stays 0 whatever arrives on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W (8) | Packet byte |
| sop_i | input | 1 | Start-of-packet strobe, high with the first byte |
| eop_i | input | 1 | End-of-packet strobe, high with the last byte |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | ADDR_W (10) | RAM write address |
| wr_data_o | output | DATA_W (8) | RAM write data |
| full_o | output | 1 | All locations written; storage stopped |

## Verification
The assertions check the following on every cycle:
- consecutive writes use consecutive addresses;
- an idle cycle without a start strobe produces no write;
- the pointer holds when nothing is accepted;
- full rises only together with the write to the top address, and is sticky;
- no write is presented while full.

Only the bench's scenarios, with a model of the RAM, can show the rest:
- packet contents land in the right locations;
- a one-byte packet stores exactly one byte;
- a stray start strobe inside a packet is kept as data;
- every location is written exactly once over a full fill that crosses a packet;
- nothing stored earlier is disturbed after the fill.

// File: rtl/pkt_wr_pkg.sv
`timescale 1ns/1ps
package pkt_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FULL = 2'd2
  } frm_state_e;
endpackage

// File: rtl/pkt_wr_frame.sv
`timescale 1ns/1ps
module pkt_wr_frame
  import pkt_wr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       eop_i,
  input  logic       last_slot_i,
  output logic       accept_o,
  output frm_state_e state_o
);
  frm_state_e state_q, state_d;

  always_comb begin
    accept_o = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: begin
        accept_o = sop_i;
        if (sop_i && !eop_i) state_d = ST_BUSY;
      end
      ST_BUSY: begin
        accept_o = 1'b1;
        if (eop_i) state_d = ST_IDLE;
      end
      default: accept_o = 1'b0;
    endcase
    // last location consumed: storage ends for good
    if (accept_o && last_slot_i) state_d = ST_FULL;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;

  AST_FULL_ABSORB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FULL |=> state_q == ST_FULL); // R10
  AST_NO_ACCEPT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FULL |-> !accept_o); // R10
endmodule

// File: rtl/pkt_wr_addr.sv
`timescale 1ns/1ps
module pkt_wr_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + 1'b1;

  assign ptr_o  = ptr_q;
  assign last_o = (ptr_q == TOP);

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ptr_q == $past(ptr_q)); // R5
endmodule

// File: rtl/pkt_ram_wr_ctrl.sv
`timescale 1ns/1ps
module pkt_ram_wr_ctrl
  import pkt_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              full_o
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic              accept;
  logic              last_slot;
  logic [ADDR_W-1:0] ptr;
  frm_state_e        state;

  pkt_wr_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sop_i       (sop_i),
    .eop_i       (eop_i),
    .last_slot_i (last_slot),
    .accept_o    (accept),
    .state_o     (state)
  );

  pkt_wr_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .ptr_o  (ptr),
    .last_o (last_slot)
  );

  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= accept;
      if (accept) begin
        wr_addr_q <= ptr;
        wr_data_q <= data_i;
      end
    end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign full_o    = (state == ST_FULL);

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q && $past(wr_en_q) |-> wr_addr_q == $past(wr_addr_q) + 1'b1); // R3
  AST_IDLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !sop_i) |=> !wr_en_q); // R4
  AST_FULL_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> wr_en_q && wr_addr_q == TOP); // R8
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(full_o) |-> full_o); // R10
  AST_NO_WRITE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && $past(full_o) |-> !wr_en_q); // R10
endmodule

// File: tb/pkt_ram_wr_ctrl_bench.sv
`timescale 1ns/1ps
module pkt_ram_wr_ctrl_bench;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              sop_i = 1'b0, eop_i = 1'b0;
  logic              wr_en_o, full_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;

  always #4 clk = ~clk; // 125 MHz

  pkt_ram_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pkt_ram_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .sop_i(sop_i), .eop_i(eop_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .full_o(full_o)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [DEPTH];
  int wcnt [DEPTH];
  int total = 0;
  bit full_at_last = 0, early_full = 0;

  // RAM model, sampled mid-cycle
  always @(negedge clk) if (rst_ni && wr_en_o) begin
    mem[wr_addr_o] = wr_data_o;
    wcnt[wr_addr_o]++;
    total++;
    if (wr_addr_o == ADDR_W'(DEPTH-1)) full_at_last = full_o;
    else if (full_o) early_full = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; wcnt[i] = 0; end
    total = 0; full_at_last = 0; early_full = 0;
  endtask

  // len bytes from base; extra start strobe at index mid_sop (-1: none)
  task automatic send_pkt(input int len, input int base, input int mid_sop);
    for (int i = 0; i < len; i++) begin
      data_i = 8'((base + i) & 8'hff);
      sop_i  = (i == 0) || (i == mid_sop);
      eop_i  = (i == len - 1);
      @(negedge clk);
    end
    sop_i = 0; eop_i = 0; data_i = 8'hee;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      data_i = 8'(8'h5a + i); sop_i = 0; eop_i = 0;
      @(negedge clk);
      chk(wr_en_o == 0, "R4", "wr_en in idle", wr_en_o, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; sop_i = 0; eop_i = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(wr_en_o == 0, "R1", "wr_en in reset", wr_en_o, 0);
    chk(wr_addr_o == 0, "R1", "addr in reset", wr_addr_o, 0);
    chk(full_o == 0, "R1", "full in reset", full_o, 0);
    clear_model();
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    send_pkt(6, 8'h10, -1);
    chk(total == 6, "R3", "basic write count", total, 6);
    chk(mem[0] == 8'h10, "R2", "first byte at 0", mem[0], 8'h10);
    for (int i = 1; i < 6; i++)
      chk(mem[i] == 8'(8'h10 + i), "R3", "basic byte", mem[i], 8'h10 + i);
    chk(wr_en_o == 0, "R3", "wr_en after end", wr_en_o, 0);
  endtask

  task automatic t_gap();
    idle(7);
    chk(total == 6, "R4", "no write in gap", total, 6);
    send_pkt(3, 8'h20, -1);
    for (int i = 0; i < 3; i++)
      chk(mem[6 + i] == 8'(8'h20 + i), "R5", "second pkt contiguous", mem[6 + i], 8'h20 + i);
  endtask

  task automatic t_one_byte();
    send_pkt(1, 8'h77, -1);
    chk(total == 10, "R6", "one-byte count", total, 10);
    chk(mem[9] == 8'h77, "R6", "one-byte data", mem[9], 8'h77);
    idle(3);
  endtask

  task automatic t_mid_sop();
    send_pkt(5, 8'h30, 2);
    chk(total == 15, "R7", "mid sop count", total, 15);
    for (int i = 0; i < 5; i++)
      chk(mem[10 + i] == 8'(8'h30 + i), "R7", "mid sop byte", mem[10 + i], 8'h30 + i);
  endtask

  task automatic t_fill();
    int bad = 0;
    chk(full_o == 0, "R8", "not full before fill", full_o, 0);
    send_pkt(DEPTH - 15 + 5, 8'h40, -1); // overruns the top by 5 bytes
    chk(full_o == 1, "R8", "full after fill", full_o, 1);
    chk(full_at_last == 1, "R8", "full with top write", full_at_last, 1);
    chk(early_full == 0, "R8", "full not early", early_full, 0);
    chk(total == DEPTH, "R9", "total writes", total, DEPTH);
    for (int i = 0; i < DEPTH; i++) if (wcnt[i] != 1) bad++;
    chk(bad == 0, "R9", "locations not written once", bad, 0);
    chk(mem[DEPTH-1] == 8'((8'h40 + DEPTH - 16) & 8'hff), "R9", "top byte",
        mem[DEPTH-1], (8'h40 + DEPTH - 16) & 8'hff);
  endtask

  task automatic t_after_full();
    send_pkt(4, 8'h99, -1);
    idle(2);
    send_pkt(1, 8'h88, -1);
    chk(total == DEPTH, "R10", "no write when full", total, DEPTH);
    chk(mem[0] == 8'h10, "R10", "loc 0 kept", mem[0], 8'h10);
    chk(full_o == 1, "R10", "full sticky", full_o, 1);
    chk(wr_en_o == 0, "R10", "wr_en low when full", wr_en_o, 0);
  endtask

  task automatic t_restart();
    do_reset();
    send_pkt(1, 8'h5c, -1);
    chk(total == 1 && wcnt[0] == 1, "R1", "restart at addr 0", wcnt[0], 1);
    chk(mem[0] == 8'h5c, "R1", "restart data", mem[0], 8'h5c);
  endtask

  initial begin
    clear_model();
    do_reset();
    t_basic();
    t_gap();
    t_one_byte();
    t_mid_sop();
    t_fill();
    t_after_full();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule